// File: doc/BRIEF.md
# Multichannel Waveform Frame Buffer with Looping Playback

This block holds frames of converter codes for eight output channels and hands one whole frame to the converter side each time a sample tick arrives while a generation runs. A frame is eight 16-bit codes packed side by side, and all eight lanes of the output change together, marked by a one-cycle update strobe. The host fills the buffer through a valid/ready write port. The converter side sees only the parallel frame bus and the strobe.

A generation continues in one of three ways, picked by a mode input that is captured at start. In streaming mode, each stored frame is played once and then discarded. In looping mode, the frames loaded while the block was idle form a fixed pattern that is replayed without end from local storage, and host writes are refused. In finite mode, frames are streamed as in streaming mode, and the generation ends by itself after a programmed number of frames. If a tick finds no frame to play, a sticky underflow flag is raised, the outputs hold the last frame and the generation halts until the error is cleared.

The controller has three states. IDLE waits for a start. RUN plays frames. HALT parks the block after an underflow. The transitions are launch (IDLE to RUN, on a start with a valid setup), stop (RUN to IDLE, on the stop pulse), finish (RUN to IDLE, when the last finite frame is played), starve (RUN to HALT, on a tick with no data) and recover (HALT to IDLE, on the error-clear pulse).

Top module: `frame_replay_buffer`

## Requirements
- R1: After reset, frame_out is zero, frame_strobe, running, underflow_err and config_err are 0, and host_ready is 1 when cfg_mode is streaming and the buffer is empty.
- R2: A tick sampled while running plays a frame. In the next cycle, frame_strobe is high for one cycle and all of frame_out changes at once. Lane i sits in bits [16i+15:16i], exactly as written on host_frame. frame_out never changes without frame_strobe.
- R3: Streaming mode (cfg_mode 0) plays the written frames in write order, each frame once. A write and a tick in the same cycle are both honoured. host_ready is 0 while 512 frames are stored, and a refused write leaves no trace.
- R4: In streaming and finite modes, a tick while running with no frame stored gives no strobe. It sets underflow_err, and the flag stays set. running drops and frame_out keeps the last frame. A frame written in that same cycle is not played, but it stays stored. clr_err clears the flag and returns the block to idle.
- R5: Looping mode (cfg_mode 1) captures the number of stored frames at start as the loop length. It replays those frames in write order and wraps from the last frame back to the first. Stopping and restarting replays the same pattern from its first frame.
- R6: While a looping generation runs, host_ready is 0 and writes are refused.
- R7: In looping mode while idle, a write that finds 512 frames stored is dropped and sets config_err. The loop length stays 512.
- R8: Finite mode (cfg_mode 2) plays exactly cfg_frames frames. running drops in the same cycle as the last strobe, and later ticks give no strobe.
- R9: A stop pulse ends a running generation. A tick in the same cycle as stop plays no frame.
- R10: The start pulse is refused, config_err is set and running stays 0 in three cases: looping mode with an empty buffer, finite mode with cfg_frames 0, or cfg_mode 3. clr_err clears config_err.
- R11: The mode and frame count are captured at start. Changing cfg_mode or cfg_frames during a run changes neither the frame total nor the write acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_valid | input | 1 | Host offers a frame |
| host_ready | output | 1 | Block accepts the offered frame |
| host_frame | input | 128 | Eight packed 16-bit codes, lane 0 in the low bits |
| cfg_mode | input | 2 | 0 streaming, 1 looping, 2 finite, 3 invalid |
| cfg_frames | input | 16 | Frame total for finite mode |
| start | input | 1 | Start pulse |
| stop | input | 1 | Stop pulse |
| clr_err | input | 1 | Clears both error flags and leaves HALT |
| tick | input | 1 | Sample tick |
| frame_out | output | 128 | Frame presented to the converters |
| frame_strobe | output | 1 | One-cycle update strobe |
| running | output | 1 | Generation in progress |
| underflow_err | output | 1 | Sticky underflow flag |
| config_err | output | 1 | Sticky setup error flag |

## Verification
Writing a frame and playing a frame can fall in the same cycle. A table of steps drives a write on every step and a tick on most steps. The frame played must be the oldest one already queued in the reference model, and the new frame must join the back of the queue. The same collision is forced on an empty buffer, where the tick must raise underflow. The frame written in that cycle must then appear first after recovery, which shows it was stored but not played. A stop and a tick are also driven together, and the result must show no strobe and a halted generation.

// File: rtl/frb_pkg.sv
package frb_pkg;
    localparam logic [1:0] MODE_STREAM = 2'd0;
    localparam logic [1:0] MODE_LOOP   = 2'd1;
    localparam logic [1:0] MODE_FINITE = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } gen_state_e;
endpackage

// File: rtl/frb_store.sv
// Circular frame storage; DEPTH must be a power of two so pointers wrap freely.
module frb_store #(
    parameter int NUM_CH   = 8,
    parameter int SAMPLE_W = 16,
    parameter int DEPTH    = 512
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            push,
    input  logic [NUM_CH*SAMPLE_W-1:0]      push_data,
    input  logic                            pop,
    input  logic [$clog2(DEPTH)-1:0]        rd_addr,
    output logic [NUM_CH*SAMPLE_W-1:0]      rd_data,
    output logic [$clog2(DEPTH)-1:0]        head,
    output logic [$clog2(DEPTH):0]          count
);
    localparam int FRAME_W = NUM_CH * SAMPLE_W;
    localparam int AW      = $clog2(DEPTH);

    logic [FRAME_W-1:0] mem [DEPTH];
    logic [AW-1:0]      wr_ptr;

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            head   <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  head   <= head + 1'b1;
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/frb_ctrl.sv
module frb_ctrl
    import frb_pkg::*;
#(
    parameter int FRAME_W = 128,
    parameter int DEPTH   = 512,
    parameter int CNT_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_valid,
    output logic                       host_ready,
    output logic                       push,
    input  logic [1:0]                 cfg_mode,
    input  logic [CNT_W-1:0]           cfg_frames,
    input  logic                       start,
    input  logic                       stop,
    input  logic                       clr_err,
    input  logic                       tick,
    input  logic [$clog2(DEPTH)-1:0]   head,
    input  logic [$clog2(DEPTH):0]     count,
    input  logic [FRAME_W-1:0]         rd_data,
    output logic                       pop,
    output logic [$clog2(DEPTH)-1:0]   rd_addr,
    output logic [FRAME_W-1:0]         frame_out,
    output logic                       frame_strobe,
    output logic                       running,
    output logic                       loop_active,
    output logic                       underflow_err,
    output logic                       config_err
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    gen_state_e       state, state_nx;
    logic [1:0]       run_mode;
    logic [CW-1:0]    loop_len;
    logic [AW-1:0]    loop_idx;
    logic [CNT_W-1:0] frames_left;

    logic full, eff_loop, start_ok, launch, bad_start, load_reject;
    logic tick_go, have_data, emit, starve, last_frame;

    assign full     = (count == CW'(DEPTH));
    assign eff_loop = (state == ST_IDLE) ? (cfg_mode == MODE_LOOP) : (run_mode == MODE_LOOP);

    // writes: refused during a looping run; a full-buffer loop load is rejected
    assign host_ready  = eff_loop ? (state == ST_IDLE) : !full;
    assign push        = host_valid && host_ready && !full;
    assign load_reject = host_valid && host_ready && full;

    always_comb begin
        unique case (cfg_mode)
            MODE_STREAM: start_ok = 1'b1;
            MODE_LOOP:   start_ok = (count != '0);
            MODE_FINITE: start_ok = (cfg_frames != '0);
            default:     start_ok = 1'b0;
        endcase
    end

    assign launch     = (state == ST_IDLE) && start && start_ok;
    assign bad_start  = (state == ST_IDLE) && start && !start_ok;
    assign tick_go    = (state == ST_RUN) && tick && !stop;
    assign have_data  = (run_mode == MODE_LOOP) || (count != '0);
    assign emit       = tick_go && have_data;
    assign starve     = tick_go && !have_data;
    assign last_frame = emit && (run_mode == MODE_FINITE) && (frames_left == CNT_W'(1));

    assign loop_active = (state != ST_IDLE) && (run_mode == MODE_LOOP);
    assign rd_addr     = loop_active ? (head + loop_idx) : head;
    assign pop         = emit && (run_mode != MODE_LOOP);
    assign running     = (state == ST_RUN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions: launch, stop, starve, finish, recover
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (launch) state_nx = ST_RUN;
            ST_RUN: begin
                if (stop)            state_nx = ST_IDLE;
                else if (starve)     state_nx = ST_HALT;
                else if (last_frame) state_nx = ST_IDLE;
            end
            ST_HALT: if (clr_err) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs and run context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_out     <= '0;
            frame_strobe  <= 1'b0;
            run_mode      <= MODE_STREAM;
            loop_len      <= '0;
            loop_idx      <= '0;
            frames_left   <= '0;
            underflow_err <= 1'b0;
            config_err    <= 1'b0;
        end else begin
            frame_strobe <= emit;
            if (emit) frame_out <= rd_data;
            if (launch) begin
                run_mode    <= cfg_mode;
                loop_len    <= count;
                loop_idx    <= '0;
                frames_left <= cfg_frames;
            end else if (emit) begin
                if (run_mode == MODE_LOOP)
                    loop_idx <= ({1'b0, loop_idx} == loop_len - 1'b1) ? '0 : loop_idx + 1'b1;
                if (run_mode == MODE_FINITE)
                    frames_left <= frames_left - 1'b1;
            end
            if (starve)       underflow_err <= 1'b1;
            else if (clr_err) underflow_err <= 1'b0;
            if (bad_start || load_reject) config_err <= 1'b1;
            else if (clr_err)             config_err <= 1'b0;
        end
    end
endmodule

// File: rtl/frame_replay_buffer.sv
module frame_replay_buffer #(
    parameter int NUM_CH   = 8,
    parameter int SAMPLE_W = 16,
    parameter int DEPTH    = 512,
    parameter int CNT_W    = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         host_valid,
    output logic                         host_ready,
    input  logic [NUM_CH*SAMPLE_W-1:0]   host_frame,
    input  logic [1:0]                   cfg_mode,
    input  logic [CNT_W-1:0]             cfg_frames,
    input  logic                         start,
    input  logic                         stop,
    input  logic                         clr_err,
    input  logic                         tick,
    output logic [NUM_CH*SAMPLE_W-1:0]   frame_out,
    output logic                         frame_strobe,
    output logic                         running,
    output logic                         underflow_err,
    output logic                         config_err
);
    localparam int FRAME_W = NUM_CH * SAMPLE_W;
    localparam int AW      = $clog2(DEPTH);

    logic               push, pop, loop_active;
    logic [AW-1:0]      head, rd_addr;
    logic [AW:0]        count;
    logic [FRAME_W-1:0] rd_data;

    frb_store #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(host_frame),
        .pop(pop), .rd_addr(rd_addr), .rd_data(rd_data), .head(head), .count(count)
    );

    frb_ctrl #(.FRAME_W(FRAME_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
        .push(push), .cfg_mode(cfg_mode), .cfg_frames(cfg_frames), .start(start),
        .stop(stop), .clr_err(clr_err), .tick(tick), .head(head), .count(count),
        .rd_data(rd_data), .pop(pop), .rd_addr(rd_addr), .frame_out(frame_out),
        .frame_strobe(frame_strobe), .running(running), .loop_active(loop_active),
        .underflow_err(underflow_err), .config_err(config_err)
    );
endmodule

// File: rtl/frb_checker.sv
module frb_checker #(
    parameter int FRAME_W = 128
) (
    input logic               clk,
    input logic               rst_n,
    input logic               host_ready,
    input logic               tick,
    input logic               stop,
    input logic               clr_err,
    input logic [FRAME_W-1:0] frame_out,
    input logic               frame_strobe,
    input logic               running,
    input logic               loop_active,
    input logic               underflow_err
);
    p_strobe_from_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |-> ($past(tick) && $past(running)));

    p_out_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_strobe |-> $stable(frame_out));

    p_underflow_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow_err && !clr_err) |=> underflow_err);

    p_underflow_halts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_err |-> !running);

    p_loop_refuses_r6: assert property (@(posedge clk) disable iff (!rst_n)
        loop_active |-> !host_ready);

    p_stop_no_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_strobe |-> !$past(stop));
endmodule

bind frame_replay_buffer frb_checker #(.FRAME_W(NUM_CH*SAMPLE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_ready(host_ready), .tick(tick), .stop(stop),
    .clr_err(clr_err), .frame_out(frame_out), .frame_strobe(frame_strobe),
    .running(running), .loop_active(loop_active), .underflow_err(underflow_err)
);

// File: tb/frame_replay_buffer_tb.sv
module frame_replay_buffer_tb;
    localparam int NCH = 8, SW = 16, DEPTH = 512, CNT_W = 16, FW = NCH * SW;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic           rst_n, host_valid, host_ready, start, stop, clr_err, tick;
    logic [FW-1:0]  host_frame, frame_out;
    logic [1:0]     cfg_mode;
    logic [CNT_W-1:0] cfg_frames;
    logic           frame_strobe, running, underflow_err, config_err;

    frame_replay_buffer #(.NUM_CH(NCH), .SAMPLE_W(SW), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
        .host_frame(host_frame), .cfg_mode(cfg_mode), .cfg_frames(cfg_frames),
        .start(start), .stop(stop), .clr_err(clr_err), .tick(tick),
        .frame_out(frame_out), .frame_strobe(frame_strobe), .running(running),
        .underflow_err(underflow_err), .config_err(config_err)
    );

    // step table: {seed, tick-in-same-cycle}
    localparam logic [16:0] STEP_TAB [8] = '{
        {16'h1000, 1'b1}, {16'h2222, 1'b1}, {16'h3A3A, 1'b0}, {16'h4004, 1'b1},
        {16'h5FF5, 1'b1}, {16'h6060, 1'b1}, {16'h7171, 1'b0}, {16'h8E08, 1'b1}
    };

    int n_tests = 0, n_fail = 0;
    bit finished = 1'b0;
    logic [FW-1:0] refq [$];

    function automatic logic [FW-1:0] mk_frame(input logic [15:0] seed);
        logic [FW-1:0] f;
        for (int i = 0; i < NCH; i++) f[i*SW +: SW] = seed ^ 16'((i + 1) * 16'h1357);
        return f;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; host_valid = 1'b0; host_frame = '0; start = 1'b0; stop = 1'b0;
        clr_err = 1'b0; tick = 1'b0; cfg_mode = 2'd0; cfg_frames = '0;
        refq.delete();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic write_frame(input logic [FW-1:0] f);
        host_valid = 1'b1; host_frame = f;
        @(negedge clk);
        host_valid = 1'b0;
    endtask

    task automatic pulse_start();
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask
    task automatic pulse_stop();
        stop = 1'b1; @(negedge clk); stop = 1'b0;
    endtask
    task automatic pulse_clr();
        clr_err = 1'b1; @(negedge clk); clr_err = 1'b0;
    endtask

    task automatic tick_once();
        tick = 1'b1; @(negedge clk); tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [FW-1:0] exp_f, last_f;
        int strobes;

        // ---- R1 reset state
        do_reset();
        #1;
        check(frame_out == '0, "R1 frame_out zero", frame_out, '0);
        check({frame_strobe, running, underflow_err, config_err} == 4'b0, "R1 flags clear",
              FW'({frame_strobe, running, underflow_err, config_err}), '0);
        check(host_ready == 1'b1, "R1 host_ready", FW'(host_ready), FW'(1));

        // ---- R2/R3 table walk: write each step, tick on flagged steps
        write_frame(mk_frame(16'h0A0A)); refq.push_back(mk_frame(16'h0A0A));
        write_frame(mk_frame(16'h0B0B)); refq.push_back(mk_frame(16'h0B0B));
        pulse_start();
        for (int s = 0; s < 8; s++) begin
            logic [FW-1:0] nf;
            nf = mk_frame(STEP_TAB[s][16:1]);
            host_valid = 1'b1; host_frame = nf; tick = STEP_TAB[s][0];
            @(negedge clk);
            host_valid = 1'b0; tick = 1'b0;
            if (STEP_TAB[s][0]) begin
                exp_f = refq.pop_front();
                check(frame_strobe && frame_out == exp_f, "R3 order with concurrent write", frame_out, exp_f);
            end else begin
                check(!frame_strobe, "R2 no strobe without tick", FW'(frame_strobe), '0);
            end
            refq.push_back(nf);
        end
        while (refq.size() > 0) begin
            exp_f = refq.pop_front();
            tick_once();
            check(frame_strobe && frame_out == exp_f, "R2 drain frame", frame_out, exp_f);
            last_f = exp_f;
        end
        check(running == 1'b1, "R3 still running", FW'(running), FW'(1));
        // ---- R4 underflow on empty store, write in same cycle
        host_valid = 1'b1; host_frame = mk_frame(16'hC0DE); tick = 1'b1;
        @(negedge clk);
        host_valid = 1'b0; tick = 1'b0;
        check(!frame_strobe && underflow_err && !running, "R4 underflow halts",
              FW'({frame_strobe, underflow_err, running}), FW'(3'b010));
        check(frame_out == last_f, "R4 output held", frame_out, last_f);
        repeat (3) @(negedge clk);
        check(underflow_err == 1'b1, "R4 flag sticky", FW'(underflow_err), FW'(1));
        pulse_clr();
        check(underflow_err == 1'b0, "R4 clear", FW'(underflow_err), '0);
        pulse_start();
        tick_once();
        check(frame_strobe && frame_out == mk_frame(16'hC0DE), "R4 same-cycle write kept",
              frame_out, mk_frame(16'hC0DE));

        // ---- R3 full buffer refuses writes
        do_reset();
        for (int k = 0; k < DEPTH; k++) write_frame(mk_frame(16'(k)));
        #1;
        check(host_ready == 1'b0, "R3 ready low when full", FW'(host_ready), '0);
        write_frame(mk_frame(16'hDEAD));
        pulse_start();
        for (int k = 0; k < DEPTH; k++) begin
            tick_once();
            if (k == DEPTH - 1)
                check(frame_strobe && frame_out == mk_frame(16'(k)), "R3 last of full load",
                      frame_out, mk_frame(16'(k)));
        end
        tick_once();
        check(underflow_err && !frame_strobe, "R3 refused write not stored",
              FW'({underflow_err, frame_strobe}), FW'(2'b10));

        // ---- R5/R6/R9 looping
        do_reset();
        cfg_mode = 2'd1;
        for (int k = 0; k < 3; k++) write_frame(mk_frame(16'h100 + 16'(k)));
        pulse_start();
        #1;
        check(host_ready == 1'b0, "R6 ready low in loop run", FW'(host_ready), '0);
        write_frame(mk_frame(16'hBAD0));
        for (int k = 0; k < 7; k++) begin
            exp_f = mk_frame(16'h100 + 16'(k % 3));
            tick_once();
            check(frame_strobe && frame_out == exp_f, "R5 loop replay and wrap", frame_out, exp_f);
        end
        stop = 1'b1; tick = 1'b1;
        @(negedge clk);
        stop = 1'b0; tick = 1'b0;
        check(!frame_strobe && !running, "R9 stop beats tick",
              FW'({frame_strobe, running}), '0);
        pulse_start();
        tick_once();
        check(frame_strobe && frame_out == mk_frame(16'h100), "R5 restart from first",
              frame_out, mk_frame(16'h100));
        pulse_stop();

        // ---- R7 loop load overflow
        do_reset();
        cfg_mode = 2'd1;
        for (int k = 0; k < DEPTH; k++) write_frame(mk_frame(16'(k)));
        #1;
        check(host_ready == 1'b1 && config_err == 1'b0, "R7 ready before overflow",
              FW'({host_ready, config_err}), FW'(2'b10));
        write_frame(mk_frame(16'hBEEF));
        check(config_err == 1'b1, "R7 overflow flagged", FW'(config_err), FW'(1));
        pulse_start();
        for (int k = 0; k < DEPTH; k++) tick_once();
        tick_once();
        check(frame_strobe && frame_out == mk_frame(16'd0), "R7 loop length stays 512",
              frame_out, mk_frame(16'd0));
        pulse_stop();

        // ---- R8/R11 finite
        do_reset();
        cfg_mode = 2'd2; cfg_frames = 16'd3;
        for (int k = 0; k < 5; k++) write_frame(mk_frame(16'h200 + 16'(k)));
        pulse_start();
        cfg_mode = 2'd1; cfg_frames = 16'd1;
        #1;
        check(host_ready == 1'b1, "R11 mode latched, writes accepted", FW'(host_ready), FW'(1));
        strobes = 0;
        for (int k = 0; k < 3; k++) begin
            tick_once();
            if (frame_strobe) strobes++;
            if (k == 1) check(running == 1'b1, "R11 count latched", FW'(running), FW'(1));
        end
        check(strobes == 3 && !running, "R8 finite stop at count",
              FW'({strobes[3:0], running}), FW'({4'd3, 1'b0}));
        tick_once();
        check(!frame_strobe, "R8 no frame after finish", FW'(frame_strobe), '0);

        // ---- R10 refused starts
        do_reset();
        cfg_mode = 2'd1;
        pulse_start();
        check(config_err && !running, "R10 loop empty", FW'({config_err, running}), FW'(2'b10));
        pulse_clr();
        check(config_err == 1'b0, "R10 clear", FW'(config_err), '0);
        cfg_mode = 2'd2; cfg_frames = '0;
        pulse_start();
        check(config_err && !running, "R10 finite zero", FW'({config_err, running}), FW'(2'b10));
        pulse_clr();
        cfg_mode = 2'd3;
        pulse_start();
        check(config_err && !running, "R10 mode 3", FW'({config_err, running}), FW'(2'b10));

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule